// File: doc/BRIEF.md
# Flash Autoselect Identifier Responder

This block sits on the read path of a banked flash device. It decides, bank by bank, whether a word-mode read returns identifier information or the array word supplied from outside. Identifier mode starts in one of two ways. A command-path pulse can select a single bank, and every other bank keeps serving array data. A high-voltage-detect level can put every bank into identifier mode at once.

In identifier mode, five low address bits pick the returned word: the manufacturer code, the device code, two extended device codes, or the protection status of one sector group. Protection state is a bank of 48 group bits, and all of them are clear after reset. A strobed protect operation, allowed only while the high-voltage level is present, sets one bit. Inputs are synchronous to `clk_i`. The read data output is a combinational function of the read address, the array input and the registered state.

Top module: `flash_autoselect`

## Requirements
- R1: After reset no bank is in identifier mode, so every read returns `array_data_i`, and all 48 protection bits are clear.
- R2: A cycle with `enter_cmd_i` high and `exit_cmd_i` low puts the bank given by `enter_bank_i` into identifier mode from the next cycle. A read whose address bits [21:19] equal that bank returns identifier data. Reads to any other bank return `array_data_i`.
- R3: In identifier mode, the word is chosen only by the five bits {A6,A3,A2,A1,A0}. Code 00000 returns the manufacturer code (default 0004h) and code 00001 returns `DEV_CODE` (default 227Eh). A7, A5, A4 and A11..A8 have no effect.
- R4: Codes 01110 and 01111 return `EXT_CODE1` and `EXT_CODE2` only when `DEV_CODE` is 227Eh. For any other device code they return 0000h.
- R5: Code 00010 returns the protection bit of group index = A21..A16 in bit 0, with bits 15..1 zero. Group indices 48 to 63 read 0.
- R6: Every other five-bit code returns 0000h in identifier mode.
- R7: While `hv_detect_i` is high, every bank returns identifier data regardless of command state. When it falls, the command state alone governs again.
- R8: `exit_cmd_i` high ends command identifier mode from the next cycle. It wins over a simultaneous `enter_cmd_i`.
- R9: A new enter pulse while already in command identifier mode moves the mode to the new bank. The old bank returns to array data.
- R10: A protect operation sets one bit. The strobe `prot_strobe_ni` falls while `hv_detect_i` is high, and A21..A12 is latched. When the strobe rises with the same A21..A12 and `hv_detect_i` still high, group A21..A16 becomes protected from the next cycle.
- R11: No bit is set in these cases: A21..A12 changed while the strobe was low, `hv_detect_i` was low at any point of the operation, or the group index is 48 or above.
- R12: Protection bits are never cleared except by `rst_ni`. Exit and enter commands leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enter_cmd_i | input | 1 | One-cycle pulse: command path enters identifier mode |
| enter_bank_i | input | BANK_W | Bank captured with the enter pulse |
| exit_cmd_i | input | 1 | Reset command: leave command identifier mode |
| hv_detect_i | input | 1 | High-voltage-detect level: all banks in identifier mode |
| rd_addr_i | input | ADDR_W | Word address A21..A0; also supplies the protect group |
| array_data_i | input | DATA_W | Array read data for banks not in identifier mode |
| prot_strobe_ni | input | 1 | Active-low protect strobe |
| rd_data_o | output | DATA_W | Read data |

## Verification
The bench builds two copies of the block. The first uses the default parameters, so 48 groups sit in a 64-entry index space, and the out-of-range group indices 48 to 63 can be used for both reads and protect attempts. The second copy has a device code other than 227Eh. It shows that the extended-code offsets fall back to 0000h. Both copies share 22 address bits and 3 bank bits. This makes bank retargeting, offset aliasing through the ignored address bits, and the top group (index 47) reachable with directed addresses.

// File: rtl/flash_as_pkg.sv
package flash_as_pkg;
  localparam logic [4:0] SEL_MFR  = 5'b00000;
  localparam logic [4:0] SEL_DEV  = 5'b00001;
  localparam logic [4:0] SEL_PROT = 5'b00010;
  localparam logic [4:0] SEL_EXT1 = 5'b01110;
  localparam logic [4:0] SEL_EXT2 = 5'b01111;
  localparam logic [15:0] EXT_FLAG_CODE = 16'h227E;

  typedef enum logic [1:0] {
    PROT_IDLE  = 2'd0,
    PROT_ARMED = 2'd1,
    PROT_SPOIL = 2'd2
  } prot_state_e;

  function automatic logic [4:0] id_sel(input logic [6:0] low);
    return {low[6], low[3:0]};
  endfunction
endpackage

// File: rtl/flash_as_mode_ctrl.sv
module flash_as_mode_ctrl #(
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_cmd_i,
  input  logic [BANK_W-1:0] enter_bank_i,
  input  logic              exit_cmd_i,
  input  logic              hv_detect_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic              cmd_active_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic              id_hit_o
);
  logic              active_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bank_q   <= '0;
    end else if (exit_cmd_i) begin
      active_q <= 1'b0;
    end else if (enter_cmd_i) begin
      active_q <= 1'b1;
      bank_q   <= enter_bank_i;
    end
  end

  assign cmd_active_o = active_q;
  assign cmd_bank_o   = bank_q;
  assign id_hit_o     = hv_detect_i | (active_q && (rd_bank_i == bank_q));
endmodule

// File: rtl/flash_as_prot_bank.sv
module flash_as_prot_bank #(
  parameter int GRP_W     = 10,
  parameter int GRP_SHIFT = 4,
  parameter int N_GROUPS  = 48,
  localparam int GIDX_W   = GRP_W - GRP_SHIFT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_ni,
  input  logic                hv_i,
  input  logic [GRP_W-1:0]    grp_i,
  output logic [N_GROUPS-1:0] prot_o
);
  import flash_as_pkg::*;

  prot_state_e        st_q;
  logic               strobe_q;
  logic [GRP_W-1:0]   grp_q;
  logic               fall, rise, set_en;
  logic [GIDX_W-1:0]  set_idx;

  assign fall    = strobe_q & ~strobe_ni;
  assign rise    = ~strobe_q & strobe_ni;
  assign set_idx = grp_q[GRP_W-1:GRP_SHIFT];
  // commit only if armed, unchanged and still under high voltage
  assign set_en  = rise && (st_q == PROT_ARMED) && hv_i && (grp_i == grp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      st_q     <= PROT_IDLE;
      grp_q    <= '0;
    end else begin
      strobe_q <= strobe_ni;
      if (fall) begin
        grp_q <= grp_i;
        st_q  <= hv_i ? PROT_ARMED : PROT_SPOIL;
      end else if (rise) begin
        st_q <= PROT_IDLE;
      end else if (st_q == PROT_ARMED && (!hv_i || grp_i != grp_q)) begin
        st_q <= PROT_SPOIL;
      end
    end
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         prot_o[g] <= 1'b0;
      else if (set_en && set_idx == GIDX_W'(g))            prot_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_as_id_decode.sv
module flash_as_id_decode #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int GRP_W     = 10,
  parameter int GRP_SHIFT = 4,
  parameter int N_GROUPS  = 48,
  parameter logic [DATA_W-1:0] MFR_CODE  = 16'h0004,
  parameter logic [DATA_W-1:0] DEV_CODE  = 16'h227E,
  parameter logic [DATA_W-1:0] EXT_CODE1 = 16'h2256,
  parameter logic [DATA_W-1:0] EXT_CODE2 = 16'h2201,
  localparam int GIDX_W   = GRP_W - GRP_SHIFT
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   array_data_i,
  input  logic                id_hit_i,
  input  logic [N_GROUPS-1:0] prot_i,
  output logic [DATA_W-1:0]   data_o
);
  import flash_as_pkg::*;

  localparam bit HAS_EXT = (DEV_CODE == DATA_W'(EXT_FLAG_CODE));

  logic [4:0]        sel;
  logic [GIDX_W-1:0] rd_idx;
  logic              prot_bit;
  logic [DATA_W-1:0] id_word;

  assign sel    = id_sel(addr_i[6:0]);
  assign rd_idx = addr_i[ADDR_W-1 -: GIDX_W];

  always_comb begin
    prot_bit = 1'b0;
    for (int g = 0; g < N_GROUPS; g++)
      if (rd_idx == GIDX_W'(g)) prot_bit = prot_i[g];
  end

  always_comb begin
    case (sel)
      SEL_MFR:  id_word = MFR_CODE;
      SEL_DEV:  id_word = DEV_CODE;
      SEL_PROT: id_word = DATA_W'(prot_bit);
      SEL_EXT1: id_word = HAS_EXT ? EXT_CODE1 : '0;
      SEL_EXT2: id_word = HAS_EXT ? EXT_CODE2 : '0;
      default:  id_word = '0;
    endcase
  end

  assign data_o = id_hit_i ? id_word : array_data_i;
endmodule

// File: rtl/flash_autoselect.sv
module flash_autoselect #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 3,
  parameter int GRP_W     = 10,
  parameter int GRP_SHIFT = 4,
  parameter int N_GROUPS  = 48,
  parameter logic [DATA_W-1:0] MFR_CODE  = 16'h0004,
  parameter logic [DATA_W-1:0] DEV_CODE  = 16'h227E,
  parameter logic [DATA_W-1:0] EXT_CODE1 = 16'h2256,
  parameter logic [DATA_W-1:0] EXT_CODE2 = 16'h2201
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_cmd_i,
  input  logic [BANK_W-1:0] enter_bank_i,
  input  logic              exit_cmd_i,
  input  logic              hv_detect_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              prot_strobe_ni,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              cmd_active;
  logic [BANK_W-1:0] cmd_bank;
  logic              id_hit;
  logic [N_GROUPS-1:0] prot_bits;

  flash_as_mode_ctrl #(.BANK_W(BANK_W)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_cmd_i  (enter_cmd_i),
    .enter_bank_i (enter_bank_i),
    .exit_cmd_i   (exit_cmd_i),
    .hv_detect_i  (hv_detect_i),
    .rd_bank_i    (rd_addr_i[ADDR_W-1 -: BANK_W]),
    .cmd_active_o (cmd_active),
    .cmd_bank_o   (cmd_bank),
    .id_hit_o     (id_hit)
  );

  flash_as_prot_bank #(
    .GRP_W(GRP_W), .GRP_SHIFT(GRP_SHIFT), .N_GROUPS(N_GROUPS)
  ) u_prot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (prot_strobe_ni),
    .hv_i      (hv_detect_i),
    .grp_i     (rd_addr_i[ADDR_W-1 -: GRP_W]),
    .prot_o    (prot_bits)
  );

  flash_as_id_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP_W(GRP_W), .GRP_SHIFT(GRP_SHIFT),
    .N_GROUPS(N_GROUPS), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
    .EXT_CODE1(EXT_CODE1), .EXT_CODE2(EXT_CODE2)
  ) u_dec (
    .addr_i       (rd_addr_i),
    .array_data_i (array_data_i),
    .id_hit_i     (id_hit),
    .prot_i       (prot_bits),
    .data_o       (rd_data_o)
  );
endmodule

// File: rtl/flash_autoselect_chk.sv
module flash_autoselect_chk #(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 3,
  parameter int N_GROUPS = 48,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0004
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enter_cmd_i,
  input logic [BANK_W-1:0]   enter_bank_i,
  input logic                exit_cmd_i,
  input logic                hv_detect_i,
  input logic [ADDR_W-1:0]   rd_addr_i,
  input logic [DATA_W-1:0]   array_data_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic                cmd_active,
  input logic [BANK_W-1:0]   cmd_bank,
  input logic [N_GROUPS-1:0] prot_bits
);
  logic [4:0] sel;
  assign sel = {rd_addr_i[6], rd_addr_i[3:0]};

  a_r2_other_bank_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hv_detect_i && !(cmd_active && rd_addr_i[ADDR_W-1 -: BANK_W] == cmd_bank))
      |-> rd_data_o == array_data_i);

  a_r2_enter_takes_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_cmd_i && !exit_cmd_i) |=> (cmd_active && cmd_bank == $past(enter_bank_i)));

  a_r8_exit_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_cmd_i |=> !cmd_active);

  a_r3_mfr_under_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_detect_i && sel == 5'b00000) |-> rd_data_o == MFR_CODE);

  a_r5_prot_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_detect_i && sel == 5'b00010) |-> rd_data_o[DATA_W-1:1] == '0);

  a_r6_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_detect_i && sel == 5'b00100) |-> rd_data_o == '0);

  a_r11_no_set_without_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_detect_i |=> $stable(prot_bits));

  a_r10_single_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(prot_bits ^ $past(prot_bits)) <= 1);

  a_r12_never_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_bits & $past(prot_bits)) == $past(prot_bits));
endmodule

bind flash_autoselect flash_autoselect_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .N_GROUPS(N_GROUPS), .MFR_CODE(MFR_CODE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enter_cmd_i  (enter_cmd_i),
  .enter_bank_i (enter_bank_i),
  .exit_cmd_i   (exit_cmd_i),
  .hv_detect_i  (hv_detect_i),
  .rd_addr_i    (rd_addr_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o),
  .cmd_active   (cmd_active),
  .cmd_bank     (cmd_bank),
  .prot_bits    (prot_bits)
);

// File: tb/flash_autoselect_bench.sv
module flash_autoselect_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enter_cmd, exit_cmd, hv, strobe_n;
  logic [2:0]  enter_bank;
  logic [21:0] addr;
  logic [15:0] arr;
  logic [15:0] rd_data, rd_plain;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flash_autoselect u_flash_autoselect (
    .clk_i(clk), .rst_ni(rst_n), .enter_cmd_i(enter_cmd), .enter_bank_i(enter_bank),
    .exit_cmd_i(exit_cmd), .hv_detect_i(hv), .rd_addr_i(addr), .array_data_i(arr),
    .prot_strobe_ni(strobe_n), .rd_data_o(rd_data)
  );

  flash_autoselect #(.DEV_CODE(16'h2233)) u_flash_autoselect_plain (
    .clk_i(clk), .rst_ni(rst_n), .enter_cmd_i(enter_cmd), .enter_bank_i(enter_bank),
    .exit_cmd_i(exit_cmd), .hv_detect_i(hv), .rd_addr_i(addr), .array_data_i(arr),
    .prot_strobe_ni(strobe_n), .rd_data_o(rd_plain)
  );

  function automatic logic [21:0] mk(input logic [9:0] grp, input logic [7:0] low);
    return {grp, 4'h0, low};
  endfunction
  function automatic logic [9:0] bank_grp(input logic [2:0] b);
    return {b, 7'h00};
  endfunction
  function automatic logic [9:0] idx_grp(input logic [5:0] k);
    return {k, 4'h0};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [21:0] a);
    addr = a;
    #1;
  endtask

  task automatic enter(input logic [2:0] b);
    enter_cmd = 1'b1; enter_bank = b; tick(); enter_cmd = 1'b0;
  endtask

  task automatic protect(input logic [9:0] g);
    addr = mk(g, 8'h02);
    strobe_n = 1'b0; tick(); tick();
    strobe_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    arr = 16'hA5A5;
    rd(mk(bank_grp(3'd2), 8'h00)); chk("R1 array after reset", rd_data, 16'hA5A5);
    rd(mk(bank_grp(3'd0), 8'h01)); chk("R1 array after reset b0", rd_data, 16'hA5A5);
    hv = 1'b1;
    rd(mk(idx_grp(6'd0), 8'h02));  chk("R1 group0 clear", rd_data, 16'h0000);
    rd(mk(idx_grp(6'd47), 8'h02)); chk("R1 group47 clear", rd_data, 16'h0000);
    hv = 1'b0; tick();
  endtask

  task automatic t_cmd_enter();
    enter(3'd2);
    rd(mk(bank_grp(3'd2), 8'h00)); chk("R2 R3 mfr", rd_data, 16'h0004);
    rd(mk(bank_grp(3'd2), 8'h01)); chk("R3 device", rd_data, 16'h227E);
    rd(mk(bank_grp(3'd2), 8'hB1) | 22'h000F00); chk("R3 ignored bits", rd_data, 16'h227E);
    rd(mk(bank_grp(3'd5), 8'h00)); chk("R2 other bank array", rd_data, 16'hA5A5);
    arr = 16'h1357;
    rd(mk(bank_grp(3'd3), 8'h01)); chk("R2 other bank follows array", rd_data, 16'h1357);
    rd(mk(bank_grp(3'd2), 8'h0E)); chk("R4 ext1", rd_data, 16'h2256);
    rd(mk(bank_grp(3'd2), 8'h0F)); chk("R4 ext2", rd_data, 16'h2201);
    chk("R4 ext2 absent plain", rd_plain, 16'h0000);
    rd(mk(bank_grp(3'd2), 8'h0E)); chk("R4 ext1 absent plain", rd_plain, 16'h0000);
    rd(mk(bank_grp(3'd2), 8'h01)); chk("R4 plain device", rd_plain, 16'h2233);
    rd(mk(bank_grp(3'd2), 8'h04)); chk("R6 unused 04", rd_data, 16'h0000);
    rd(mk(bank_grp(3'd2), 8'h40)); chk("R6 unused A6", rd_data, 16'h0000);
    rd(mk(bank_grp(3'd2), 8'h08)); chk("R6 unused 08", rd_data, 16'h0000);
  endtask

  task automatic t_retarget();
    enter(3'd6);
    rd(mk(bank_grp(3'd6), 8'h00)); chk("R9 new bank id", rd_data, 16'h0004);
    rd(mk(bank_grp(3'd2), 8'h00)); chk("R9 old bank array", rd_data, 16'h1357);
  endtask

  task automatic t_exit();
    exit_cmd = 1'b1; enter_cmd = 1'b1; enter_bank = 3'd4; tick();
    exit_cmd = 1'b0; enter_cmd = 1'b0;
    rd(mk(bank_grp(3'd4), 8'h00)); chk("R8 exit wins b4", rd_data, 16'h1357);
    rd(mk(bank_grp(3'd6), 8'h00)); chk("R8 exit wins b6", rd_data, 16'h1357);
    enter(3'd1);
    rd(mk(bank_grp(3'd1), 8'h01)); chk("R8 reenter", rd_data, 16'h227E);
    exit_cmd = 1'b1; tick(); exit_cmd = 1'b0;
    rd(mk(bank_grp(3'd1), 8'h01)); chk("R8 plain exit", rd_data, 16'h1357);
  endtask

  task automatic t_hv();
    hv = 1'b1;
    for (int b = 0; b < 8; b++) begin
      rd(mk(bank_grp(3'(b)), 8'h00)); chk("R7 hv all banks", rd_data, 16'h0004);
    end
    hv = 1'b0;
    rd(mk(bank_grp(3'd3), 8'h00)); chk("R7 hv dropped", rd_data, 16'h1357);
  endtask

  task automatic t_protect();
    hv = 1'b1;
    protect(idx_grp(6'd5));
    rd(mk(idx_grp(6'd5), 8'h02)); chk("R10 R5 group5 set", rd_data, 16'h0001);
    rd(mk(idx_grp(6'd6), 8'h02)); chk("R5 group6 clear", rd_data, 16'h0000);
    rd(mk(idx_grp(6'd5) | 10'h00F, 8'h32)); chk("R5 group low bits ignored", rd_data, 16'h0001);
    protect(idx_grp(6'd47));
    rd(mk(idx_grp(6'd47), 8'h02)); chk("R10 group47 set", rd_data, 16'h0001);
    // address moves while strobe low
    addr = mk(idx_grp(6'd7), 8'h02); strobe_n = 1'b0; tick();
    addr = mk(idx_grp(6'd8), 8'h02); tick();
    addr = mk(idx_grp(6'd7), 8'h02); tick();
    strobe_n = 1'b1; tick();
    rd(mk(idx_grp(6'd7), 8'h02)); chk("R11 spoiled group7", rd_data, 16'h0000);
    rd(mk(idx_grp(6'd8), 8'h02)); chk("R11 spoiled group8", rd_data, 16'h0000);
    // hv low at the falling edge
    hv = 1'b0; addr = mk(idx_grp(6'd9), 8'h02); strobe_n = 1'b0; tick();
    hv = 1'b1; tick(); strobe_n = 1'b1; tick();
    rd(mk(idx_grp(6'd9), 8'h02)); chk("R11 hv low at start", rd_data, 16'h0000);
    // hv dips while strobe low
    addr = mk(idx_grp(6'd10), 8'h02); strobe_n = 1'b0; tick();
    hv = 1'b0; tick(); hv = 1'b1; strobe_n = 1'b1; tick();
    rd(mk(idx_grp(6'd10), 8'h02)); chk("R11 hv dip", rd_data, 16'h0000);
    protect(idx_grp(6'd50));
    rd(mk(idx_grp(6'd50), 8'h02)); chk("R11 R5 invalid group", rd_data, 16'h0000);
    rd(mk(idx_grp(6'd2), 8'h02)); chk("R11 invalid no alias", rd_data, 16'h0000);
    hv = 1'b0; tick();
  endtask

  task automatic t_sticky();
    enter(3'd0); exit_cmd = 1'b1; tick(); exit_cmd = 1'b0; enter(3'd0);
    rd(mk(idx_grp(6'd5), 8'h02)); chk("R12 group5 kept cmd mode", rd_data, 16'h0001);
    hv = 1'b1;
    rd(mk(idx_grp(6'd47), 8'h02)); chk("R12 group47 kept", rd_data, 16'h0001);
    hv = 1'b0; exit_cmd = 1'b1; tick(); exit_cmd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enter_cmd = 1'b0; exit_cmd = 1'b0; hv = 1'b0; strobe_n = 1'b1;
    enter_bank = '0; addr = '0; arr = 16'hA5A5;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_cmd_enter();
    t_retarget();
    t_exit();
    t_hv();
    t_protect();
    t_sticky();
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule